// File: doc/BRIEF.md
# ADC Conversion Control Unit

This block is the digital side of a successive-approximation converter. It holds a byte-wide control/status register and a channel register. It divides the system clock down to a converter clock and counts out each conversion in cycles of that clock. When a conversion ends, it captures the converter's 10-bit result into a data register, raises a done flag and, if allowed, requests an interrupt. The analog converter sits outside the block. It sees the channel code and hands back a result value.

A conversion can be started in three ways: by software writing the start bit, by a rising edge on an external trigger pin, or by free-running restart, where each conversion launches the next. The first conversion after the unit is enabled runs a longer initialisation sequence. Every later conversion uses the short length.

Top module: `adcc_ctrl`

## Requirements
- R1: After reset, every control/status bit reads 0 and the result register and the interrupt request are 0. The control/status layout is: bit 0 enable, bit 1 start/busy, bit 2 auto-trigger enable, bit 3 done flag, bit 4 interrupt enable, bits 7:5 prescaler select.
- R2: Writing 0 to enable aborts a conversion that is in progress. The busy bit reads 0 on the next cycle, and the done flag and the result register are left unchanged.
- R3: A register write with the start bit and the enable bit both at 1 begins a conversion when none is in progress. A write with the start bit at 0 starts nothing.
- R4: The start bit reads 1 from the cycle after the start until the conversion completes. It then returns to 0, unless a free-running restart takes place.
- R5: The first conversion after enable rises lasts 25 converter-clock cycles. This also holds when enable and start are written together. Every later conversion lasts 13 cycles. In system-clock cycles a conversion lasts length × divider, counted from the starting clock edge.
- R6: Prescaler select n divides the system clock by 2^n for n = 1..7. Code 0 divides by 2.
- R7: With auto-trigger enable at 1 and the free_run input at 1, each completion starts the next conversion on the same edge. Clearing auto-trigger enable lets the current conversion finish and stops the chain.
- R8: With auto-trigger enable at 1 and free_run at 0, a rising edge of trig_in starts a conversion. A level held high starts nothing further, and an edge that arrives during a conversion is ignored.
- R9: The done flag is set on the edge where a conversion completes, and the result register is updated on that same edge. A write with bit 3 at 1 clears the flag, as does a pulse on irq_ack. A write with bit 3 at 0 leaves it set.
- R10: irq is 1 exactly when the done flag, the interrupt enable bit and gie are all 1.
- R11: ch_sel follows the last value written to the channel register. Code 11110 drives ch_is_bandgap to 1 and code 11111 drives ch_is_ground to 1.
- R12: The result register changes only on the completing edge of a conversion, once per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Write strobe for the control/status register |
| csr_wdata | input | 8 | Control/status write data |
| csr_rdata | output | 8 | Control/status read value |
| ch_wr | input | 1 | Write strobe for the channel register |
| ch_wdata | input | CH_W | Channel write data |
| ch_sel | output | CH_W | Channel code to the analog front end |
| ch_is_bandgap | output | 1 | Channel code selects the internal reference |
| ch_is_ground | output | 1 | Channel code selects ground |
| trig_in | input | 1 | External conversion trigger |
| free_run | input | 1 | Trigger source: 1 = restart on completion, 0 = trig_in edge |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the done flag |
| conv_result | input | RES_W | Result from the converter, sampled at completion |
| result_q | output | RES_W | Latched conversion result |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
A wrong divider count or a wrong length choice shows up as a completion edge that lands one or more whole converter periods away from length × divider. The scoreboard timestamps every change of result_q against that prediction, so the error appears on the very first conversion that uses the faulty setting. A stuck busy or done state, or a missed abort, appears as a result write that nothing expected, or as an expected write that never comes. A lost initialisation flag moves the first conversion's completion 12 converter periods early.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
    localparam int PS_W     = 3;
    localparam int CSR_W    = 5 + PS_W;
    localparam int B_EN     = 0;
    localparam int B_GO     = 1;
    localparam int B_AUTO   = 2;
    localparam int B_DONE   = 3;
    localparam int B_IE     = 4;
    localparam int B_PS     = 5;
    localparam int LEN_INIT = 25;
    localparam int LEN_NORM = 13;
    localparam int LEN_W    = $clog2(LEN_INIT);

    typedef struct packed {
        logic            en;
        logic            auto_trig;
        logic            ie;
        logic [PS_W-1:0] ps;
    } csr_t;
endpackage

// File: rtl/adcc_clkdiv.sv
module adcc_clkdiv #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);
    localparam int CNT_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] pre;
    } div_st_t;

    div_st_t          cur_q, nxt_d;
    logic [CNT_W-1:0] lim;

    always_comb begin
        int unsigned shift_n;
        shift_n = (sel == '0) ? 1 : int'(sel);
        lim     = CNT_W'((1 << shift_n) - 1);
        tick    = run && (cur_q.pre == lim);
        nxt_d   = cur_q;
        if (!run || tick) nxt_d.pre = '0;
        else              nxt_d.pre = cur_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R6: the counter never runs past the selected limit
    assert_pre_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(sel)) |-> (cur_q.pre <= lim))
        else $error("prescaler count beyond limit");
endmodule

// File: rtl/adcc_seq.sv
module adcc_seq #(
    parameter int LEN_INIT = 25,
    parameter int LEN_NORM = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic rearm,
    input  logic tick,
    input  logic init_pend,
    output logic busy,
    output logic complete
);
    localparam int LEN_W = $clog2(LEN_INIT);

    typedef struct packed {
        logic             busy;
        logic [LEN_W-1:0] cnt;
    } seq_st_t;

    seq_st_t          cur_q, nxt_d;
    logic [LEN_W-1:0] len_m1;

    always_comb begin
        len_m1   = init_pend ? LEN_W'(LEN_INIT - 1) : LEN_W'(LEN_NORM - 1);
        complete = cur_q.busy && tick && (cur_q.cnt == len_m1);
        nxt_d    = cur_q;
        if (!en) begin
            nxt_d.busy = 1'b0;
            nxt_d.cnt  = '0;
        end else if (complete) begin
            nxt_d.busy = rearm;
            nxt_d.cnt  = '0;
        end else if (!cur_q.busy) begin
            nxt_d.busy = start;
            nxt_d.cnt  = '0;
        end else if (tick) begin
            nxt_d.cnt  = cur_q.cnt + 1'b1;
        end
    end

    assign busy = cur_q.busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R5: the count stays inside the selected conversion length
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.busy |-> (cur_q.cnt <= len_m1))
        else $error("conversion count beyond length");

    // R2: a disabled unit is idle one cycle later
    assert_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !cur_q.busy)
        else $error("conversion survived disable");
endmodule

// File: rtl/adcc_ctrl.sv
module adcc_ctrl
    import adcc_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             ch_wr,
    input  logic [CH_W-1:0]  ch_wdata,
    output logic [CH_W-1:0]  ch_sel,
    output logic             ch_is_bandgap,
    output logic             ch_is_ground,
    input  logic             trig_in,
    input  logic             free_run,
    input  logic             gie,
    input  logic             irq_ack,
    input  logic [RES_W-1:0] conv_result,
    output logic [RES_W-1:0] result_q,
    output logic             irq
);
    localparam logic [CH_W-1:0] CH_GROUND  = '1;
    localparam logic [CH_W-1:0] CH_BANDGAP = CH_GROUND - 1'b1;

    typedef struct packed {
        csr_t             csr;
        logic             done;
        logic             init_pend;
        logic             trig_prev;
        logic [CH_W-1:0]  ch;
        logic [RES_W-1:0] res;
    } top_st_t;

    top_st_t cur_q, nxt_d;
    logic    start_req, rearm, busy, complete, tick;

    always_comb begin
        logic sw_start, hw_start;
        nxt_d = cur_q;
        if (csr_wr) begin
            nxt_d.csr.en        = csr_wdata[B_EN];
            nxt_d.csr.auto_trig = csr_wdata[B_AUTO];
            nxt_d.csr.ie        = csr_wdata[B_IE];
            nxt_d.csr.ps        = csr_wdata[B_PS +: PS_W];
        end
        if (nxt_d.csr.en && !cur_q.csr.en) nxt_d.init_pend = 1'b1;
        else if (complete)                 nxt_d.init_pend = 1'b0;

        sw_start  = csr_wr && csr_wdata[B_GO];
        hw_start  = cur_q.csr.auto_trig && !free_run && trig_in && !cur_q.trig_prev;
        start_req = sw_start || hw_start;
        rearm     = nxt_d.csr.auto_trig && free_run;

        if (complete)                                    nxt_d.done = 1'b1;
        else if ((csr_wr && csr_wdata[B_DONE]) || irq_ack) nxt_d.done = 1'b0;

        if (complete) nxt_d.res = conv_result;
        if (ch_wr)    nxt_d.ch  = ch_wdata;
        nxt_d.trig_prev = trig_in;

        csr_rdata                 = '0;
        csr_rdata[B_EN]           = cur_q.csr.en;
        csr_rdata[B_GO]           = busy;
        csr_rdata[B_AUTO]         = cur_q.csr.auto_trig;
        csr_rdata[B_DONE]         = cur_q.done;
        csr_rdata[B_IE]           = cur_q.csr.ie;
        csr_rdata[B_PS +: PS_W]   = cur_q.csr.ps;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    adcc_clkdiv #(.PS_W(PS_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .sel   (cur_q.csr.ps),
        .tick  (tick)
    );

    adcc_seq #(.LEN_INIT(LEN_INIT), .LEN_NORM(LEN_NORM)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (nxt_d.csr.en),
        .start     (start_req),
        .rearm     (rearm),
        .tick      (tick),
        .init_pend (cur_q.init_pend),
        .busy      (busy),
        .complete  (complete)
    );

    assign ch_sel        = cur_q.ch;
    assign ch_is_bandgap = (cur_q.ch == CH_BANDGAP);
    assign ch_is_ground  = (cur_q.ch == CH_GROUND);
    assign result_q      = cur_q.res;
    assign irq           = cur_q.done && cur_q.csr.ie && gie;

    // R9: completion raises the done flag on the next cycle
    assert_done_after_complete_R9: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> cur_q.done)
        else $error("done flag missing after completion");

    // R12: the result register moves only on a completing edge
    assert_result_on_complete_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q.res) |-> $past(complete))
        else $error("result written outside completion");

    // R3: busy rises only after a start request
    assert_busy_from_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_req))
        else $error("busy without a start");
endmodule

// File: tb/tb_adcc_ctrl.sv
module tb_adcc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] EN = 8'h01, GO = 8'h02, AUTO = 8'h04, DONE = 8'h08, IE = 8'h10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       csr_wr = 1'b0, ch_wr = 1'b0;
    logic [7:0] csr_wdata = '0, csr_rdata;
    logic [4:0] ch_wdata = '0, ch_sel;
    logic       ch_is_bandgap, ch_is_ground;
    logic       trig_in = 1'b0, free_run = 1'b0, gie = 1'b0, irq_ack = 1'b0, irq;
    logic [9:0] conv_result, result_q;
    int         cyc = 0;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    typedef struct { int when; logic [9:0] val; } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [9:0] stub_val(int c);
        return 10'(512 + (c % 512));
    endfunction
    assign conv_result = stub_val(cyc);

    adcc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .ch_wr(ch_wr), .ch_wdata(ch_wdata), .ch_sel(ch_sel), .ch_is_bandgap(ch_is_bandgap),
        .ch_is_ground(ch_is_ground), .trig_in(trig_in), .free_run(free_run), .gie(gie),
        .irq_ack(irq_ack), .conv_result(conv_result), .result_q(result_q), .irq(irq)
    );

    function automatic logic [7:0] ps(int n);
        return 8'(n << 5);
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void push_end(int c_end);
        exp_t e;
        e.when = c_end + 1;
        e.val  = stub_val(c_end);
        sbq.push_back(e);
    endfunction

    task automatic csr_write(logic [7:0] wd);
        @(negedge clk); csr_wr = 1'b1; csr_wdata = wd;
        @(negedge clk); csr_wr = 1'b0;
    endtask

    task automatic run_conv(logic [7:0] wd, int len, int dv, string req);
        @(negedge clk);
        push_end(cyc + len * dv);
        csr_wr = 1'b1; csr_wdata = wd;
        @(negedge clk); csr_wr = 1'b0;
        chk("R4", int'(csr_rdata[1]), 1, "busy right after start");
        repeat (len * dv - 1) @(negedge clk);
        chk(req, int'(csr_rdata[1]), 1, "busy in last cycle");
        @(negedge clk);
        chk(req, int'(csr_rdata[1]), 0, "busy cleared at length");
        chk("R9", int'(csr_rdata[3]), 1, "done set at completion");
    endtask

    // scoreboard monitor
    initial begin
        logic [9:0] prev;
        prev = '0;
        forever begin
            @(negedge clk);
            if (rst_n && result_q !== prev) begin
                if (sbq.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R12 unexpected result write: actual %0d expected none", result_q);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk("R5", cyc, e.when, "completion cycle");
                    chk("R9", int'(result_q), int'(e.val), "latched result");
                end
                prev = result_q;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [9:0] saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1", int'(csr_rdata), 0, "csr after reset");
        chk("R1", int'(result_q), 0, "result after reset");
        chk("R1", int'(irq), 0, "irq after reset");

        // R3: enable without start starts nothing
        csr_write(EN);
        repeat (60) @(negedge clk);
        chk("R3", int'(csr_rdata), 1, "zero start bit has no effect");

        // R5: first conversion after enable is long, div 2
        run_conv(EN | GO, 25, 2, "R5");
        // R9: writing 0 to done keeps it
        csr_write(EN | ps(3));
        chk("R9", int'(csr_rdata[3]), 1, "done kept by zero write");
        // R6: later conversions, dividers 8 and 128
        run_conv(EN | GO | ps(3), 13, 8, "R6");
        run_conv(EN | GO | ps(7), 13, 128, "R6");
        run_conv(EN | GO | ps(1), 13, 2, "R6");

        // R10 and irq_ack
        csr_write(EN | IE);
        chk("R10", int'(irq), 0, "irq masked by gie");
        @(negedge clk); gie = 1'b1;
        @(negedge clk);
        chk("R10", int'(irq), 1, "irq with all enables");
        irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R9", int'(csr_rdata[3]), 0, "ack clears done");
        chk("R10", int'(irq), 0, "irq drops with done");

        // R9: write-one-to-clear
        run_conv(EN | GO | IE, 13, 2, "R5");
        chk("R10", int'(irq), 1, "irq after completion");
        csr_write(EN | IE | DONE);
        chk("R9", int'(csr_rdata[3]), 0, "done cleared by one");
        chk("R10", int'(irq), 0, "irq after clear");

        // R2: abort
        saved = result_q;
        csr_write(EN | GO);
        repeat (10) @(negedge clk);
        csr_write(8'h00);
        chk("R2", int'(csr_rdata[1]), 0, "busy cleared by disable");
        repeat (100) @(negedge clk);
        chk("R2", int'(csr_rdata[3]), 0, "no done after abort");
        chk("R12", int'(result_q), int'(saved), "result unchanged by abort");

        // R5: enable and start together gives the long conversion
        run_conv(EN | GO, 25, 2, "R5");

        // R8: trigger edges
        csr_write(EN | AUTO);
        @(negedge clk);
        push_end(cyc + 26);
        trig_in = 1'b1;
        @(negedge clk);
        chk("R8", int'(csr_rdata[1]), 1, "trigger edge starts");
        repeat (10) @(negedge clk);
        trig_in = 1'b0;
        @(negedge clk); trig_in = 1'b1;   // edge during busy: ignored
        repeat (80) @(negedge clk);
        chk("R8", sbq.size(), 0, "one conversion for held and busy edges");
        chk("R8", int'(csr_rdata[1]), 0, "idle with level held");
        trig_in = 1'b0;
        @(negedge clk);
        push_end(cyc + 26);
        trig_in = 1'b1;
        repeat (30) @(negedge clk);
        chk("R8", sbq.size(), 0, "second edge converts");
        trig_in = 1'b0;

        // R7: free running chain of three
        free_run = 1'b1;
        @(negedge clk);
        push_end(cyc + 26);
        push_end(cyc + 52);
        push_end(cyc + 78);
        csr_wr = 1'b1; csr_wdata = EN | AUTO | GO;
        @(negedge clk); csr_wr = 1'b0;
        repeat (64) @(negedge clk);
        chk("R7", int'(csr_rdata[1]), 1, "chain still busy");
        csr_write(EN);
        repeat (60) @(negedge clk);
        chk("R7", sbq.size(), 0, "chain of three completions");
        chk("R7", int'(csr_rdata[1]), 0, "chain stopped");
        free_run = 1'b0;

        // R11: channel decode
        @(negedge clk); ch_wr = 1'b1; ch_wdata = 5'b11110;
        @(negedge clk); ch_wr = 1'b0;
        chk("R11", int'(ch_sel), 30, "channel code");
        chk("R11", int'({ch_is_bandgap, ch_is_ground}), 2, "bandgap decode");
        @(negedge clk); ch_wr = 1'b1; ch_wdata = 5'b11111;
        @(negedge clk); ch_wr = 1'b0;
        chk("R11", int'({ch_is_bandgap, ch_is_ground}), 1, "ground decode");
        @(negedge clk); ch_wr = 1'b1; ch_wdata = 5'b00101;
        @(negedge clk); ch_wr = 1'b0;
        chk("R11", int'({ch_sel, ch_is_bandgap, ch_is_ground}), 5 << 2, "plain channel");

        repeat (5) @(negedge clk);
        chk("R12", sbq.size(), 0, "scoreboard drained");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule